// File: doc/BRIEF.md
# Synchronous Burst Flash Read Engine

This block is the read path of a flash array that can serve data either as a plain asynchronous lookup or as a clocked burst. The array is a synthesizable ROM whose contents are computed from a seed parameter. With chip enable and output enable both low and no burst in progress, the output word follows the address input combinationally.

A burst starts when the load strobe is sampled low on a rising clock edge. The full address is captured at that edge. After a programmable number of clock cycles the first word is presented and a valid flag rises. From then on, each edge with the advance strobe low moves a 5-bit word counter forward. This counter wraps inside a 32-word group, and the upper address bits stay fixed. An edge with the advance strobe high suspends the burst and keeps the same word on the outputs. An active-low end flag marks the last word of each 32-word pass, counted from the loaded start. A new load restarts the burst at any time. A synchronous burst-disable input or the asynchronous reset returns the engine to asynchronous reads.

Top module: `burst_flash_read`

## Requirements
- R1: In asynchronous mode with `ceN` and `oeN` both low, `dataOut` equals the array word at `addr` in the same cycle. The array word at address a is the low DATA_W bits of a*40503 + ROM_SEED, with the default ROM_SEED of 0x1234.
- R2: A rising edge with `loadN` low captures `addr` and enters burst mode. `dataValid` is low for the next LATENCY-1 edges and rises on the LATENCY-th edge after the load edge. From then on, `dataOut` shows the word at the captured address. While `dataValid` is low in burst mode, `dataOut` is zero.
- R3: An edge with `advN` low while `dataValid` is high adds one to address bits [4:0], wrapping from 31 to 0. Bits [ADDR_W-1:5] do not change.
- R4: An edge with `advN` high leaves the presented word unchanged (suspend). A later edge with `advN` low resumes from the held word.
- R5: Advances given in burst mode before `dataValid` rises are ignored. The first valid word is the captured start word, even if `advN` was held low throughout the latency.
- R6: `endN` is low exactly while 31 advances modulo 32 have been taken since the last load, and `dataValid` is high. It goes high on the next advance, and the word sequence then repeats.
- R7: A load during an active burst ends that burst. It clears `dataValid` and starts a new burst at the address present at that edge.
- R8: An edge with `burstDisable` high leaves burst mode, with priority over a load. `dataValid` clears and `dataOut` again follows `addr`.
- R9: While `rstN` is low, the engine is in asynchronous mode with `dataValid` low and `endN` high.
- R10: If `ceN` or `oeN` is high, `dataOe` is low and `dataOut` is zero. Output enable does not affect the burst position: advances given while the outputs are disabled still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| loadN | input | 1 | Load burst start address, active low |
| advN | input | 1 | Advance burst word, active low |
| burstDisable | input | 1 | Leave burst mode at the next edge, active high |
| addr | input | ADDR_W | Word address |
| dataOut | output | DATA_W | Read data, zero while outputs are disabled |
| dataOe | output | 1 | High when the outputs are driven |
| dataValid | output | 1 | Burst word ready |
| endN | output | 1 | Last word of the 32-word pass, active low |

## Verification
The hardest condition to reach from the ports is the end flag falling on the word just before the counter wraps, after a run of more than 32 advances that began with advances the engine had to ignore. The stimulus starts a burst at word 2 of the top 32-word group and holds `advN` low without a break from the load edge onward. This covers the ignored advances during the latency, the wrap from 31 to 0 with the upper bits unchanged, and the second pass of the end flag, all in one run. A second burst after a mid-burst restart checks that the end flag counts from the new start and not from the group boundary.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic load;   // capture a new start address
    logic step;   // move to the next word in the group
  } burstStrobe_t;

  // Array content: a hashed address, truncated by the caller
  function automatic logic [31:0] romWord(input logic [31:0] wordAddr,
                                          input logic [31:0] seed);
    return wordAddr * 32'd40503 + seed;
  endfunction

endpackage

// File: rtl/bfr_ctrl.sv
module bfr_ctrl
  import bfr_pkg::*;
#(
  parameter int unsigned LATENCY = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadN,
  input  logic         advN,
  input  logic         burstDisable,
  output burstStrobe_t strobe,
  output logic         burstMode,
  output logic         dataValid,
  output logic         endN
);

  localparam int WAIT_W = $clog2(LATENCY + 1);
  localparam int GROUP_W = 5;

  logic [WAIT_W-1:0]  waitCnt;
  logic [GROUP_W-1:0] advCnt;

  assign strobe.load = !loadN && !burstDisable;
  assign strobe.step = burstMode && dataValid && !advN && loadN && !burstDisable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstMode <= 1'b0;
      dataValid <= 1'b0;
      waitCnt   <= '0;
      advCnt    <= '0;
    end else if (burstDisable) begin
      burstMode <= 1'b0;
      dataValid <= 1'b0;
      waitCnt   <= '0;
      advCnt    <= '0;
    end else if (!loadN) begin
      burstMode <= 1'b1;
      dataValid <= 1'b0;
      waitCnt   <= WAIT_W'(LATENCY);
      advCnt    <= '0;
    end else if (burstMode) begin
      if (!dataValid) begin
        if (waitCnt == WAIT_W'(1)) dataValid <= 1'b1;
        waitCnt <= waitCnt - WAIT_W'(1);
      end else if (!advN) begin
        advCnt <= advCnt + GROUP_W'(1);
      end
    end
  end

  assign endN = !(burstMode && dataValid && (advCnt == {GROUP_W{1'b1}}));

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !burstDisable) |=> (burstMode && !dataValid)); // R7

  AST_DISABLE_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    burstDisable |=> (!burstMode && !dataValid)); // R8

  AST_EARLY_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> (advCnt == '0)); // R5

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!endN && !advN && loadN && !burstDisable) |=> endN); // R6

endmodule

// File: rtl/bfr_datapath.sv
module bfr_datapath
  import bfr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 16,
  parameter logic [31:0] ROM_SEED = 32'h1234
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobe,
  input  logic              burstMode,
  input  logic              dataValid,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int GROUP_W = 5;
  localparam int UPPER_W = ADDR_W - GROUP_W;

  logic [ADDR_W-1:0] burstAddr;
  logic [ADDR_W-1:0] readAddr;
  logic [DATA_W-1:0] arrayWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstAddr <= '0;
    end else if (strobe.load) begin
      burstAddr <= addr;
    end else if (strobe.step) begin
      burstAddr <= {burstAddr[ADDR_W-1:GROUP_W],
                    burstAddr[GROUP_W-1:0] + GROUP_W'(1)};
    end
  end

  assign readAddr  = burstMode ? burstAddr : addr;
  assign arrayWord = DATA_W'(romWord(32'(readAddr), ROM_SEED));
  assign dataOe    = !ceN && !oeN;

  always_comb begin
    if (!dataOe)                     dataOut = '0;
    else if (burstMode && !dataValid) dataOut = '0;
    else                              dataOut = arrayWord;
  end

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ((burstAddr[GROUP_W-1:0] == $past(burstAddr[GROUP_W-1:0]) + GROUP_W'(1))
                     && (burstAddr[ADDR_W-1:GROUP_W] == $past(burstAddr[ADDR_W-1:GROUP_W])))); // R3

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> $stable(burstAddr)); // R4

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> (dataOut == '0)); // R10

  initial begin
    assert (UPPER_W > 0) else $error("ADDR_W must exceed the group width");
  end

endmodule

// File: rtl/burst_flash_read.sv
module burst_flash_read
  import bfr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LATENCY  = 3,
  parameter logic [31:0] ROM_SEED = 32'h1234
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              loadN,
  input  logic              advN,
  input  logic              burstDisable,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dataValid,
  output logic              endN
);

  burstStrobe_t strobe;
  logic         burstMode;

  bfr_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .loadN        (loadN),
    .advN         (advN),
    .burstDisable (burstDisable),
    .strobe       (strobe),
    .burstMode    (burstMode),
    .dataValid    (dataValid),
    .endN         (endN)
  );

  bfr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_SEED(ROM_SEED)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .burstMode (burstMode),
    .dataValid (dataValid),
    .ceN       (ceN),
    .oeN       (oeN),
    .addr      (addr),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

  AST_ASYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (!burstMode && dataOe) |-> (dataOut == DATA_W'(romWord(32'(addr), ROM_SEED)))); // R1

endmodule

// File: tb/burst_flash_read_bench.sv
module burst_flash_read_bench;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN, ceN, oeN, loadN, advN, burstDisable;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe, dataValid, endN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_flash_read u_burst_flash_read (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .loadN(loadN), .advN(advN),
    .burstDisable(burstDisable), .addr(addr), .dataOut(dataOut), .dataOe(dataOe),
    .dataValid(dataValid), .endN(endN)
  );

  localparam logic [ADDR_W-1:0] ASYNC_VEC [8] = '{
    10'h000, 10'h001, 10'h01F, 10'h020, 10'h155, 10'h2AA, 10'h3E0, 10'h3FF
  };

  function automatic logic [DATA_W-1:0] refWord(input logic [ADDR_W-1:0] a);
    logic [31:0] full;
    full = {22'd0, a} * 32'd40503 + 32'h1234;
    return full[DATA_W-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b0; oeN = 1'b0; loadN = 1'b1; advN = 1'b1;
    burstDisable = 1'b0; addr = '0;
    #1;
    chk("R9 reset valid", 32'(dataValid), 0);
    chk("R9 reset end", 32'(endN), 1);
    step(); step();
    rstN = 1'b1;

    // R1: table of asynchronous reads
    foreach (ASYNC_VEC[i]) begin
      addr = ASYNC_VEC[i];
      #1;
      chk("R1 async read", 32'(dataOut), 32'(refWord(ASYNC_VEC[i])));
    end

    // R2/R5: load at word 2 of the top group, advance held low from the start
    step();
    addr = 10'h3E2; loadN = 1'b0; advN = 1'b0;
    step();
    loadN = 1'b1; addr = 10'h055;
    #1;
    chk("R2 valid low after load", 32'(dataValid), 0);
    chk("R2 data zero in latency", 32'(dataOut), 0);
    step(); step();
    chk("R2 valid still low", 32'(dataValid), 0);
    step();
    chk("R2 valid high", 32'(dataValid), 1);
    chk("R5 early advances ignored", 32'(dataOut), 32'(refWord(10'h3E2)));
    chk("R6 end high at start", 32'(endN), 1);

    // R3/R6: 40 advances through the wrap and past the end
    for (int k = 1; k <= 40; k++) begin
      step();
      chk("R3 wrap sequence", 32'(dataOut), 32'(refWord({5'd31, 5'((2 + k) % 32)})));
      chk("R6 end flag", 32'(endN), ((k % 32) == 31) ? 0 : 1);
    end

    // R4: suspend
    advN = 1'b1;
    step();
    chk("R4 suspend hold 1", 32'(dataOut), 32'(refWord({5'd31, 5'd10})));
    step();
    chk("R4 suspend hold 2", 32'(dataOut), 32'(refWord({5'd31, 5'd10})));
    advN = 1'b0;
    step();
    chk("R4 resume", 32'(dataOut), 32'(refWord({5'd31, 5'd11})));

    // R10: output enable gating, burst keeps moving
    oeN = 1'b1;
    #1;
    chk("R10 data gated", 32'(dataOut), 0);
    chk("R10 oe low", 32'(dataOe), 0);
    step(); step();
    oeN = 1'b0; advN = 1'b1;
    #1;
    chk("R10 position kept", 32'(dataOut), 32'(refWord({5'd31, 5'd13})));
    chk("R10 oe high", 32'(dataOe), 1);

    // R7: restart mid-burst
    addr = 10'h015; loadN = 1'b0;
    step();
    loadN = 1'b1;
    chk("R7 restart clears valid", 32'(dataValid), 0);
    step(); step(); step();
    chk("R7 restart valid", 32'(dataValid), 1);
    chk("R7 restart word", 32'(dataOut), 32'(refWord(10'h015)));
    advN = 1'b0;
    for (int k = 1; k <= 31; k++) step();
    chk("R6 end relative to start", 32'(endN), 0);
    chk("R6 last word", 32'(dataOut), 32'(refWord(10'h014)));
    step();
    chk("R6 end clears on repeat", 32'(endN), 1);
    chk("R6 sequence repeats", 32'(dataOut), 32'(refWord(10'h015)));

    // R8: burst disable, with a simultaneous load that must lose
    burstDisable = 1'b1; loadN = 1'b0; advN = 1'b1;
    step();
    burstDisable = 1'b0; loadN = 1'b1; addr = 10'h2AB;
    #1;
    chk("R8 valid cleared", 32'(dataValid), 0);
    chk("R8 async again", 32'(dataOut), 32'(refWord(10'h2AB)));

    // R9: reset from burst mode
    addr = 10'h100; loadN = 1'b0;
    step();
    loadN = 1'b1;
    step(); step(); step();
    chk("R9 burst valid before reset", 32'(dataValid), 1);
    rstN = 1'b0; addr = 10'h0F0;
    #1;
    chk("R9 valid cleared", 32'(dataValid), 0);
    chk("R9 async after reset", 32'(dataOut), 32'(refWord(10'h0F0)));
    step();
    rstN = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule